// File: doc/BRIEF.md
# Two-Context Thread Slot Manager

This block keeps track of which hardware threads occupy the two execution contexts of one core in a tiled multicore. Threads can migrate between cores. One context, the home slot, is reserved for a thread that was created on this core. The other context, the visitor slot, takes any thread whose birth core is elsewhere. When a migrating thread arrives, the block places it in the slot its origin calls for. If a foreign thread arrives while the visitor slot is taken, the resident visitor is pushed out. An outbound request then sends that visitor to its own birth core. Sending a displaced thread home keeps the migration system free of deadlock, because a thread's home slot can never be taken by anyone else.

Threads are represented only by an identifier and the index of their birth core. Moving the register contents, routing on the network and the pipeline are all handled elsewhere. The block also picks which of the resident threads issues in each cycle. When both contexts are occupied, the two threads take turns cycle by cycle.

Top module: `ctx_slot_mgr`

## Requirements
- R1: After a synchronous active-low reset, both slots are empty, no eviction request is pending and `run_valid` is 0.
- R2: An arrival whose `arr_home` equals `core_id` is accepted into the home slot when that slot is empty (or departing in the same cycle). `arr_take` is 1 in the arrival cycle, and `home_tid` shows the thread from the next cycle on.
- R3: An arrival with `arr_home` equal to `core_id` while the home slot is occupied and not departing raises `arr_clash` in that cycle. It is not accepted, and the home slot keeps its thread.
- R4: A foreign arrival (`arr_home` not equal to `core_id`) while the visitor slot is empty is accepted into the visitor slot with no eviction.
- R5: A foreign arrival while the visitor slot is occupied is accepted. From the next cycle on, the visitor slot holds the new thread, and `out_valid` is 1 with `out_tid` set to the displaced thread and `out_dest` set to that thread's birth core.
- R6: A pending eviction keeps `out_valid`, `out_tid` and `out_dest` unchanged until a cycle with `out_ready` at 1. After that cycle, `out_valid` is 0 unless a new eviction was loaded.
- R7: A foreign arrival that would displace the visitor while an earlier eviction is pending and `out_ready` is 0 is not accepted. Neither slot nor the eviction request changes.
- R8: `leave_home` or `leave_visit` clears that slot from the next cycle on. A foreign arrival in the same cycle as `leave_visit` replaces the visitor without an eviction.
- R9: `run_slot` is 0 for the home slot and 1 for the visitor slot. With both slots occupied, it alternates every cycle. With one slot occupied, it names that slot. With none, `run_valid` is 0. `run_tid` is the thread in the named slot.
- R10: `arr_take` and `arr_clash` are 0 whenever `arr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_id | input | CORE_W | Index of this core, held constant |
| arr_valid | input | 1 | An inbound migrating thread is offered |
| arr_tid | input | TID_W | Identifier of the arriving thread |
| arr_home | input | CORE_W | Birth core of the arriving thread |
| arr_take | output | 1 | Arrival accepted this cycle |
| arr_clash | output | 1 | Arrival refused: home slot already held |
| leave_home | input | 1 | Home-slot thread departs this cycle |
| leave_visit | input | 1 | Visitor-slot thread departs this cycle |
| home_valid | output | 1 | Home slot occupied |
| home_tid | output | TID_W | Thread in the home slot |
| visit_valid | output | 1 | Visitor slot occupied |
| visit_tid | output | TID_W | Thread in the visitor slot |
| visit_home | output | CORE_W | Birth core of the visitor |
| run_valid | output | 1 | A thread is selected to issue |
| run_slot | output | 1 | Selected slot: 0 home, 1 visitor |
| run_tid | output | TID_W | Selected thread |
| out_valid | output | 1 | Eviction request pending |
| out_tid | output | TID_W | Evicted thread |
| out_dest | output | CORE_W | Destination core of the evicted thread |
| out_ready | input | 1 | Network takes the eviction request |

## Verification
`arr_take` and `arr_clash` are combinational, so they are sampled in the arrival cycle itself, before the clock edge that would commit the arrival. Slot contents, the eviction request and the cleared slot state after a departure sit one register stage away. They are sampled just after the next rising edge. The selected thread follows the slot registers and the turn register, so the alternation check compares two samples taken one full cycle apart while both slots are held. Inputs change on falling edges, so every sample is taken well clear of the rising edge.

// File: rtl/ctx_pkg.sv
// Package: shared slot encoding for the two-context slot manager.
// Assumes exactly two contexts per core: index 0 is home, index 1 is visitor.
package ctx_pkg;
    typedef enum logic {
        SLOT_HOME  = 1'b0,
        SLOT_VISIT = 1'b1
    } slot_e;
endpackage

// File: rtl/ctx_decide.sv
// Module: ctx_decide
// Purpose: combinational placement decision for one arriving thread.
// Assumes: slot valids and pending-eviction state are current registered
// values; same-cycle departures free their slot for this decision.
module ctx_decide #(
    parameter int CORE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] core_id,
    input  logic              arr_valid,
    input  logic [CORE_W-1:0] arr_home,
    input  logic              home_valid,
    input  logic              visit_valid,
    input  logic              leave_home,
    input  logic              leave_visit,
    input  logic              out_valid,
    input  logic              out_ready,
    output logic              take_home,
    output logic              take_visit,
    output logic              load_evict,
    output logic              clash
);
    logic is_local;
    logic home_free;
    logic visit_free;
    logic buf_free;

    // Classify the arrival and decide which slot, if any, takes it.
    always_comb begin
        is_local   = (arr_home == core_id);
        home_free  = !home_valid || leave_home;
        visit_free = !visit_valid || leave_visit;
        buf_free   = !out_valid || out_ready;
        take_home  = arr_valid && is_local && home_free;
        take_visit = arr_valid && !is_local && (visit_free || buf_free);
        load_evict = take_visit && !visit_free;
        clash      = arr_valid && is_local && !home_free;
    end

    // R7: no displacement may be issued while the earlier request is stuck.
    assert_no_stacked_evict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !load_evict);

    // R10: no verdict without an offered arrival.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_valid |-> (!take_home && !take_visit && !clash));
endmodule

// File: rtl/ctx_evict_buf.sv
// Module: ctx_evict_buf
// Purpose: single-entry outbound request holding an evicted visitor until
// the network accepts it with a valid/ready handshake.
// Assumes: the loader only loads when the entry is empty or being taken.
module ctx_evict_buf #(
    parameter int TID_W  = 8,
    parameter int CORE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TID_W-1:0]  load_tid,
    input  logic [CORE_W-1:0] load_dest,
    output logic              out_valid,
    output logic [TID_W-1:0]  out_tid,
    output logic [CORE_W-1:0] out_dest,
    input  logic              out_ready
);
    // Hold the request; drop it on handshake, replace it on a new load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tid   <= '0;
            out_dest  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_tid   <= load_tid;
            out_dest  <= load_dest;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R6: a request not yet taken stays put, unchanged.
    assert_evict_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tid) && $stable(out_dest)));
endmodule

// File: rtl/ctx_sched.sv
// Module: ctx_sched
// Purpose: picks which resident context issues each cycle.
// Assumes: a free-running turn bit; both contexts share issue equally.
module ctx_sched #(
    parameter int TID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             home_valid,
    input  logic [TID_W-1:0] home_tid,
    input  logic             visit_valid,
    input  logic [TID_W-1:0] visit_tid,
    output logic             run_valid,
    output logic             run_slot,
    output logic [TID_W-1:0] run_tid
);
    import ctx_pkg::*;

    logic  turn;
    slot_e pick;

    // Turn bit flips every cycle to share issue between two residents.
    always_ff @(posedge clk) begin
        if (!rst_n) turn <= 1'b0;
        else        turn <= !turn;
    end

    // Choose the issuing slot from occupancy and the turn bit.
    always_comb begin
        if (home_valid && visit_valid) pick = turn ? SLOT_VISIT : SLOT_HOME;
        else if (visit_valid)          pick = SLOT_VISIT;
        else                           pick = SLOT_HOME;
        run_valid = home_valid || visit_valid;
        run_slot  = pick;
        run_tid   = (pick == SLOT_VISIT) ? visit_tid : home_tid;
    end

    // R9: two residents held across an edge take turns.
    assert_alternate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (home_valid && visit_valid) |=>
            (!(home_valid && visit_valid) || (run_slot != $past(run_slot))));

    // R9: the chosen slot is always an occupied one.
    assert_pick_occupied_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_valid |-> (run_slot ? visit_valid : home_valid));
endmodule

// File: rtl/ctx_slot_mgr.sv
// Module: ctx_slot_mgr (top)
// Purpose: holds the home and visitor contexts of one core, places arriving
// threads, pushes out displaced visitors toward their birth core, and
// selects the issuing thread.
// Assumes: core_id is constant while out of reset; threads are IDs only.
module ctx_slot_mgr #(
    parameter int TID_W  = 8,
    parameter int CORE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] core_id,
    input  logic              arr_valid,
    input  logic [TID_W-1:0]  arr_tid,
    input  logic [CORE_W-1:0] arr_home,
    output logic              arr_take,
    output logic              arr_clash,
    input  logic              leave_home,
    input  logic              leave_visit,
    output logic              home_valid,
    output logic [TID_W-1:0]  home_tid,
    output logic              visit_valid,
    output logic [TID_W-1:0]  visit_tid,
    output logic [CORE_W-1:0] visit_home,
    output logic              run_valid,
    output logic              run_slot,
    output logic [TID_W-1:0]  run_tid,
    output logic              out_valid,
    output logic [TID_W-1:0]  out_tid,
    output logic [CORE_W-1:0] out_dest,
    input  logic              out_ready
);
    logic take_home;
    logic take_visit;
    logic load_evict;

    ctx_decide #(.CORE_W(CORE_W)) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_id    (core_id),
        .arr_valid  (arr_valid),
        .arr_home   (arr_home),
        .home_valid (home_valid),
        .visit_valid(visit_valid),
        .leave_home (leave_home),
        .leave_visit(leave_visit),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .take_home  (take_home),
        .take_visit (take_visit),
        .load_evict (load_evict),
        .clash      (arr_clash)
    );

    // Accept flag is the union of the two placement outcomes.
    always_comb arr_take = take_home || take_visit;

    // Home slot register: fill on local arrival, clear on departure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            home_valid <= 1'b0;
            home_tid   <= '0;
        end else if (take_home) begin
            home_valid <= 1'b1;
            home_tid   <= arr_tid;
        end else if (leave_home) begin
            home_valid <= 1'b0;
        end
    end

    // Visitor slot register: overwrite on foreign arrival, clear on departure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            visit_valid <= 1'b0;
            visit_tid   <= '0;
            visit_home  <= '0;
        end else if (take_visit) begin
            visit_valid <= 1'b1;
            visit_tid   <= arr_tid;
            visit_home  <= arr_home;
        end else if (leave_visit) begin
            visit_valid <= 1'b0;
        end
    end

    ctx_evict_buf #(.TID_W(TID_W), .CORE_W(CORE_W)) u_evict (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_evict),
        .load_tid (visit_tid),
        .load_dest(visit_home),
        .out_valid(out_valid),
        .out_tid  (out_tid),
        .out_dest (out_dest),
        .out_ready(out_ready)
    );

    ctx_sched #(.TID_W(TID_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .home_valid (home_valid),
        .home_tid   (home_tid),
        .visit_valid(visit_valid),
        .visit_tid  (visit_tid),
        .run_valid  (run_valid),
        .run_slot   (run_slot),
        .run_tid    (run_tid)
    );

    // R3: a refused local arrival leaves the home resident in place.
    assert_clash_keeps_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_clash |=> (home_valid && $stable(home_tid)));

    // R4: the visitor slot never holds a thread born on this core.
    assert_visitor_foreign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        visit_valid |-> (visit_home != core_id));

    // R5: a displacement sends the old visitor toward its birth core.
    assert_evict_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_evict |=> (out_valid && out_tid == $past(visit_tid) && out_dest == $past(visit_home)));
endmodule

// File: tb/tb_ctx_slot_mgr.sv
module tb_ctx_slot_mgr;
    localparam int TID_W  = 8;
    localparam int CORE_W = 6;
    localparam logic [CORE_W-1:0] ME = 6'd5;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CORE_W-1:0] core_id;
    logic              arr_valid;
    logic [TID_W-1:0]  arr_tid;
    logic [CORE_W-1:0] arr_home;
    logic              arr_take, arr_clash;
    logic              leave_home, leave_visit;
    logic              home_valid, visit_valid;
    logic [TID_W-1:0]  home_tid, visit_tid;
    logic [CORE_W-1:0] visit_home;
    logic              run_valid, run_slot;
    logic [TID_W-1:0]  run_tid;
    logic              out_valid;
    logic [TID_W-1:0]  out_tid;
    logic [CORE_W-1:0] out_dest;
    logic              out_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = !clk;

    ctx_slot_mgr #(.TID_W(TID_W), .CORE_W(CORE_W)) dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive an arrival at the falling edge and settle.
    task automatic offer(input int tid, input int home);
        @(negedge clk);
        arr_valid = 1'b1; arr_tid = TID_W'(tid); arr_home = CORE_W'(home);
        #1;
    endtask

    // Commit at the next rising edge, drop inputs, settle past the edge.
    task automatic commit();
        @(posedge clk); #1;
        arr_valid = 1'b0; leave_home = 1'b0; leave_visit = 1'b0; out_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 home_valid", home_valid, 0);
        chk("R1 visit_valid", visit_valid, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 run_valid", run_valid, 0);
    endtask

    task automatic t_home_fill();
        offer(1, ME);
        chk("R2 take", arr_take, 1);
        chk("R2 clash", arr_clash, 0);
        commit();
        chk("R2 home_valid", home_valid, 1);
        chk("R2 home_tid", home_tid, 1);
        chk("R9 single slot", run_slot, 0);
        chk("R9 run_tid", run_tid, 1);
    endtask

    task automatic t_home_clash();
        offer(9, ME);
        chk("R3 clash", arr_clash, 1);
        chk("R3 take", arr_take, 0);
        commit();
        chk("R3 home_tid kept", home_tid, 1);
    endtask

    task automatic t_idle_quiet();
        @(negedge clk);
        arr_valid = 1'b0; arr_home = ME; #1;
        chk("R10 clash idle", arr_clash, 0);
        chk("R10 take idle", arr_take, 0);
    endtask

    task automatic t_visit_fill();
        offer(20, 2);
        chk("R4 take", arr_take, 1);
        commit();
        chk("R4 visit_tid", visit_tid, 20);
        chk("R4 visit_home", visit_home, 2);
        chk("R4 no evict", out_valid, 0);
    endtask

    task automatic t_alternate();
        int s0, t0;
        @(negedge clk);
        s0 = run_slot; t0 = run_tid;
        chk("R9 tid matches slot", t0, (s0 != 0) ? 20 : 1);
        @(negedge clk);
        chk("R9 alternate", run_slot, 1 - s0);
        chk("R9 tid after turn", run_tid, (s0 != 0) ? 1 : 20);
    endtask

    task automatic t_displace();
        offer(30, 3);
        chk("R5 take", arr_take, 1);
        commit();
        chk("R5 visit_tid", visit_tid, 30);
        chk("R5 out_valid", out_valid, 1);
        chk("R5 out_tid", out_tid, 20);
        chk("R5 out_dest", out_dest, 2);
        repeat (3) @(posedge clk);
        #1;
        chk("R6 hold valid", out_valid, 1);
        chk("R6 hold tid", out_tid, 20);
    endtask

    task automatic t_stall();
        offer(40, 4);
        chk("R7 refused", arr_take, 0);
        commit();
        chk("R7 visitor kept", visit_tid, 30);
        chk("R7 request kept", out_tid, 20);
    endtask

    task automatic t_handshake();
        @(negedge clk);
        out_ready = 1'b1;
        commit();
        chk("R6 released", out_valid, 0);
    endtask

    task automatic t_leave_swap();
        offer(50, 1);
        leave_visit = 1'b1; #1;
        chk("R8 take with leave", arr_take, 1);
        commit();
        chk("R8 new visitor", visit_tid, 50);
        chk("R8 no evict", out_valid, 0);
    endtask

    task automatic t_leave_home();
        @(negedge clk);
        leave_home = 1'b1;
        commit();
        chk("R8 home cleared", home_valid, 0);
        chk("R9 visitor only", run_slot, 1);
        chk("R9 run_tid visitor", run_tid, 50);
        @(negedge clk);
        leave_visit = 1'b1;
        commit();
        chk("R8 visitor cleared", visit_valid, 0);
        chk("R9 none", run_valid, 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; core_id = ME;
        arr_valid = 1'b0; arr_tid = '0; arr_home = '0;
        leave_home = 1'b0; leave_visit = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_home_fill();
        t_home_clash();
        t_idle_quiet();
        t_visit_fill();
        t_alternate();
        t_displace();
        t_stall();
        t_handshake();
        t_leave_swap();
        t_leave_home();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule